// File: doc/BRIEF.md
# Coarse Phase/Frequency Detector with Lock Window

This block compares two single-cycle pulse streams: one from the reference divider and one from the main divider. The pulse that arrives first opens a correction interval. A reference pulse that leads asks the loop to move up. A main pulse that leads asks it to move down. The interval closes when the other pulse arrives. The coarse correction output is modelled as two drive enables, `pumpUp` and `pumpDown`, together with an output-enable, `coarseEn`. When `coarseEn` is low, the coarse pin is treated as high impedance.

While the interval is open, a counter measures the phase error as the number of clock cycles between the two pulses. When the comparison completes, the error is checked against a programmable window, once per reference period. If the error fits inside the window, the coarse drive is released and the active-low lock flag `lockN` goes low. A finer detector outside this block then holds the loop in lock. A later comparison that falls outside the window re-enables the coarse drive and raises `lockN` in the same cycle. A reload pulse, issued when the divider counters are reprogrammed, forces the block back to the unlocked, idle condition.

Top module: `pfd_lock_top`

## Requirements
- R1: After reset, `pumpUp` and `pumpDown` are 0 and `coarseEn` and `lockN` are 1.
- R2: When unlocked, a reference pulse that arrives while no comparison is open raises `pumpUp` from the next cycle. `pumpUp` stays high until the main pulse is sampled, and `pumpDown` stays 0 throughout.
- R3: When unlocked, a main pulse that arrives while no comparison is open raises `pumpDown` from the next cycle. `pumpDown` stays high until the reference pulse is sampled, and `pumpUp` stays 0 throughout.
- R4: Reference and main pulses sampled in the same cycle drive neither pump and count as an error of 0 cycles.
- R5: The cycle after the closing pulse is sampled, both pumps are 0.
- R6: The error is the number of clock cycles between the sampling of the two pulses. If it is less than or equal to `window`, then from the cycle after the closing pulse `lockN` is 0 and `coarseEn` is 0. While locked, both pumps are held at 0.
- R7: If the error is greater than `window`, then from the cycle after the closing pulse `lockN` is 1 and `coarseEn` is 1.
- R8: A `reload` pulse makes `lockN` 1, `coarseEn` 1 and both pumps 0 in the next cycle, and discards any open comparison. Reference or main pulses sampled in the same cycle as `reload` are ignored.
- R9: The error counter saturates at 2^CW-1 instead of wrapping. A very late closing pulse therefore never appears to fall inside the window.
- R10: `lockN` and `coarseEn` change only on a completed comparison or on `reload`. They hold their value while the block is idle or waiting for the closing pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| refPulse | input | 1 | One-cycle pulse from the reference divider |
| mainPulse | input | 1 | One-cycle pulse from the main divider |
| reload | input | 1 | Counter-reload strobe; clears lock and any open comparison |
| window | input | CW (8) | Lock window as a count of clock cycles, inclusive |
| pumpUp | output | 1 | Coarse output drive-high enable |
| pumpDown | output | 1 | Coarse output drive-low enable |
| coarseEn | output | 1 | Coarse output enable; 0 means high impedance |
| lockN | output | 1 | Lock flag, active low |

## Verification
The bench probes the window boundaries: an error equal to the window, one cycle beyond it, and a zero window with coincident pulses. A design whose compare was off by one would lock or unlock on the wrong side of these cases. It sends correction pulses while the block is locked, which catches a design whose pumps leak through the released output. It holds a comparison open for longer than the counter can count, so a counter that wraps would show a false lock. It also issues reload in the same cycle as a reference pulse, which exposes a design that lets the pulse open a new comparison or keeps a stale lock.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  typedef enum logic [1:0] {
    PD_IDLE = 2'd0,
    PD_UP   = 2'd1,
    PD_DOWN = 2'd2
  } pdState_t;

  // strobes from control to the error datapath
  typedef struct packed {
    logic cntStart;  // first edge seen: load count with 1
    logic cntRun;    // waiting for closing edge: advance count
    logic zeroErr;   // both edges in one cycle: error is 0
  } cntCtl_t;

endpackage

// File: rtl/pfd_err_path.sv
module pfd_err_path
  import pfd_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  cntCtl_t       ctl,
  input  logic [CW-1:0] window,
  output logic          inWindow
);

  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [CW-1:0] errCnt;
  logic [CW-1:0] errNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errCnt <= '0;
    end else if (ctl.cntStart) begin
      errCnt <= CW'(1);
    end else if (ctl.cntRun && (errCnt != CNT_MAX)) begin
      errCnt <= errCnt + CW'(1);
    end
  end

  always_comb begin
    errNow   = ctl.zeroErr ? '0 : errCnt;
    inWindow = (errNow <= window);
  end

  // R9
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.cntRun && !ctl.cntStart && errCnt == CNT_MAX) |=> (errCnt == CNT_MAX));

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.cntStart) |=> (errCnt == CW'(1)));

endmodule

// File: rtl/pfd_ctrl.sv
module pfd_ctrl
  import pfd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    refPulse,
  input  logic    mainPulse,
  input  logic    reload,
  input  logic    inWindow,
  output cntCtl_t ctl,
  output logic    pumpUp,
  output logic    pumpDown,
  output logic    coarseEn,
  output logic    lockN
);

  pdState_t state, stateNext;
  logic     locked;
  logic     done;

  always_comb begin
    stateNext    = state;
    done         = 1'b0;
    ctl.cntStart = 1'b0;
    ctl.cntRun   = 1'b0;
    ctl.zeroErr  = 1'b0;
    if (reload) begin
      stateNext = PD_IDLE;
    end else begin
      unique case (state)
        PD_IDLE: begin
          if (refPulse && mainPulse) begin
            done        = 1'b1;
            ctl.zeroErr = 1'b1;
          end else if (refPulse) begin
            stateNext    = PD_UP;
            ctl.cntStart = 1'b1;
          end else if (mainPulse) begin
            stateNext    = PD_DOWN;
            ctl.cntStart = 1'b1;
          end
        end
        PD_UP: begin
          if (mainPulse) begin
            stateNext = PD_IDLE;
            done      = 1'b1;
          end else begin
            ctl.cntRun = 1'b1;
          end
        end
        PD_DOWN: begin
          if (refPulse) begin
            stateNext = PD_IDLE;
            done      = 1'b1;
          end else begin
            ctl.cntRun = 1'b1;
          end
        end
        default: stateNext = PD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= PD_IDLE;
      locked <= 1'b0;
    end else begin
      state <= stateNext;
      if (reload) begin
        locked <= 1'b0;
      end else if (done) begin
        locked <= inWindow;
      end
    end
  end

  always_comb begin
    pumpUp   = (state == PD_UP) && !locked;
    pumpDown = (state == PD_DOWN) && !locked;
    coarseEn = !locked;
    lockN    = !locked;
  end

  // R4
  coincident_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == PD_IDLE && refPulse && mainPulse && !reload) |=> (state == PD_IDLE && !pumpUp && !pumpDown));

  // R6
  enter_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && inWindow && !reload) |=> (!lockN && !coarseEn));

  // R7
  leave_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !inWindow && !reload) |=> (lockN && coarseEn));

  // R8
  reload_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    reload |=> (lockN && coarseEn && !pumpUp && !pumpDown && state == PD_IDLE));

  // R10
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!done && !reload) |=> $stable(lockN));

  // R5
  close_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != PD_IDLE && done) |=> (!pumpUp && !pumpDown));

endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
  import pfd_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          refPulse,
  input  logic          mainPulse,
  input  logic          reload,
  input  logic [CW-1:0] window,
  output logic          pumpUp,
  output logic          pumpDown,
  output logic          coarseEn,
  output logic          lockN
);

  cntCtl_t ctl;
  logic    inWindow;

  pfd_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .refPulse  (refPulse),
    .mainPulse (mainPulse),
    .reload    (reload),
    .inWindow  (inWindow),
    .ctl       (ctl),
    .pumpUp    (pumpUp),
    .pumpDown  (pumpDown),
    .coarseEn  (coarseEn),
    .lockN     (lockN)
  );

  pfd_err_path #(.CW(CW)) uErr (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .window   (window),
    .inWindow (inWindow)
  );

  // R2 R3
  pump_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(pumpUp && pumpDown));

endmodule

// File: tb/sim_pfd_lock_top.sv
module sim_pfd_lock_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refPulse = 1'b0;
  logic       mainPulse = 1'b0;
  logic       reload = 1'b0;
  logic [7:0] window = 8'd0;
  logic       pumpUp, pumpDown, coarseEn, lockN;

  int total = 0;
  int bad = 0;
  logic expLockN = 1'b1;

  always #5 clk = ~clk;

  pfd_lock_top #(.CW(8)) u0 (
    .clk(clk), .rstN(rstN), .refPulse(refPulse), .mainPulse(mainPulse),
    .reload(reload), .window(window), .pumpUp(pumpUp), .pumpDown(pumpDown),
    .coarseEn(coarseEn), .lockN(lockN)
  );

  // {window[7:0], gap[7:0], refFirst, expLockN}
  localparam logic [17:0] VEC [8] = '{
    {8'd4,  8'd3,  1'b1, 1'b0},
    {8'd4,  8'd4,  1'b0, 1'b0},
    {8'd4,  8'd5,  1'b1, 1'b1},
    {8'd0,  8'd0,  1'b1, 1'b0},
    {8'd0,  8'd1,  1'b0, 1'b1},
    {8'd10, 8'd10, 1'b1, 1'b0},
    {8'd10, 8'd2,  1'b0, 1'b0},
    {8'd9,  8'd10, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chkOut(input string req, input logic eUp, input logic eDn, input logic eLockN);
    chk({req, " pumpUp"}, int'(pumpUp), int'(eUp));
    chk({req, " pumpDown"}, int'(pumpDown), int'(eDn));
    chk({req, " lockN"}, int'(lockN), int'(eLockN));
    chk({req, " coarseEn"}, int'(coarseEn), int'(eLockN));
  endtask

  // first pulse sampled at edge P0, closing pulse at edge P_gap
  task automatic runPair(input logic refFirst, input int gap, input logic expAfter, input string req);
    logic eUp, eDn;
    eUp = refFirst && expLockN;
    eDn = !refFirst && expLockN;
    @(negedge clk);
    if (gap == 0) begin
      refPulse = 1'b1; mainPulse = 1'b1;
    end else if (refFirst) begin
      refPulse = 1'b1;
    end else begin
      mainPulse = 1'b1;
    end
    for (int k = 1; k <= gap; k++) begin
      @(negedge clk);
      refPulse = 1'b0; mainPulse = 1'b0;
      chkOut({req, " R2 R3 R10 open"}, eUp, eDn, expLockN);
      if (k == gap) begin
        if (refFirst) mainPulse = 1'b1; else refPulse = 1'b1;
      end
    end
    @(negedge clk);
    refPulse = 1'b0; mainPulse = 1'b0;
    expLockN = expAfter;
    chkOut({req, " R5 close"}, 1'b0, 1'b0, expLockN);
    repeat (2) @(negedge clk);
    chkOut({req, " R10 idle hold"}, 1'b0, 1'b0, expLockN);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chkOut("R1 in reset", 1'b0, 1'b0, 1'b1);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chkOut("R1 after reset", 1'b0, 1'b0, 1'b1);

    // table walk: R4 R6 R7 boundaries, pump gating while locked
    foreach (VEC[i]) begin
      window = VEC[i][17:10];
      runPair(VEC[i][1], int'(VEC[i][9:2]), VEC[i][0],
              VEC[i][0] ? "R7 vec" : "R6 R4 vec");
    end

    // R8: reload while locked
    window = 8'd6;
    runPair(1'b1, 2, 1'b0, "R6 relock");
    @(negedge clk);
    reload = 1'b1;
    @(negedge clk);
    reload = 1'b0;
    expLockN = 1'b1;
    chkOut("R8 reload clears lock", 1'b0, 1'b0, 1'b1);

    // R8: ref pulse in the same cycle as reload is ignored
    @(negedge clk);
    reload = 1'b1; refPulse = 1'b1;
    @(negedge clk);
    reload = 1'b0; refPulse = 1'b0;
    chkOut("R8 pulse with reload ignored", 1'b0, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    chkOut("R8 still idle", 1'b0, 1'b0, 1'b1);

    // R8: reload discards an open comparison
    @(negedge clk);
    mainPulse = 1'b1;
    @(negedge clk);
    mainPulse = 1'b0;
    chkOut("R3 open before reload", 1'b0, 1'b1, 1'b1);
    reload = 1'b1;
    @(negedge clk);
    reload = 1'b0;
    chkOut("R8 open comparison dropped", 1'b0, 1'b0, 1'b1);
    // a later ref pulse must open a fresh up interval
    refPulse = 1'b1;
    @(negedge clk);
    refPulse = 1'b0;
    chkOut("R8 R2 fresh interval", 1'b1, 1'b0, 1'b1);
    mainPulse = 1'b1;
    @(negedge clk);
    mainPulse = 1'b0;
    expLockN = 1'b0;
    chkOut("R6 fresh interval locks", 1'b0, 1'b0, 1'b0);

    // R9: very late closing pulse, counter must saturate, not wrap
    window = 8'd50;
    runPair(1'b1, 300, 1'b1, "R9 saturate");

    // R6 window equal to counter maximum accepts the saturated error
    window = 8'd255;
    runPair(1'b0, 300, 1'b0, "R9 R6 max window");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule